// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block asks a parallel NOR flash bank what it is. A start pulse makes it send the identify command sequence on a simple synchronous memory bus. The bus has a word address, write data, read data, a write strobe and a read strobe. After the sequence the block waits a settling time that is set by parameters. It then reads the manufacturer word and, when that is recognised, the device word.

The block then reports three things: which vendor command family the part belongs to, a type index taken from a parameter table, and the sector count and byte size of the part. On a successful identification it writes the family's return-to-read command. The sequence works for two command families that do not share a command set. An unlock-style part acts on all three writes. A status-register-style part ignores the two unlock writes and acts only on the last one.

The identify sequence is meant to run once after power-up, or whenever the bank is swapped. It must own the bus for the whole probe.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, busy, done, bus_we and bus_re are low, and id_vendor, id_type, id_sectors and id_bytes are all zero.
- R2: A start pulse while idle causes three bus writes on three consecutive cycles, each with the write strobe high for that cycle only. The writes are 0x00AA to word address 0x555, then 0x0055 to 0x2AA, then 0x0090 to 0x555.
- R3: The first read strobe comes exactly CLK_MHZ*SETTLE_US+1 cycles after the cycle of the third write. Neither strobe is active in between.
- R4: The manufacturer read goes to word address 0, and only bits 7:0 of the returned word are compared. A value equal to neither VEND_UNLOCK nor VEND_STATUS ends the probe with id_vendor=0, id_type=0, id_sectors=0 and id_bytes=0. In that case no further read and no further write occur.
- R5: For a recognised manufacturer, the device read goes to word address 1 and all DATA_W bits are compared with the table. No match ends the probe with all result fields zero, and no further write occurs.
- R6: A device word equal to table entry i gives id_type=i+1, with id_sectors and id_bytes taken from entry i. id_vendor is 1 for the unlock-style vendor and 2 for the status-register-style vendor.
- R7: After a successful match, exactly one write goes to word address 0. It carries 0x00F0 for the unlock-style vendor and 0x00FF for the status-register-style vendor.
- R8: done is high for exactly one cycle at the end of a probe. The result fields are valid in that cycle and are held until the next accepted start. A start while busy is ignored.
- R9: Read data is taken from bus_rdata in the cycle after the read strobe. The value on bus_rdata in any other cycle has no effect.
- R10: bus_we and bus_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (accepted when idle) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_re |
| id_vendor | output | 2 | 0 unknown, 1 unlock-style, 2 status-register-style |
| id_type | output | TYPE_W | Table index plus one, 0 when unknown |
| id_sectors | output | 16 | Sector count |
| id_bytes | output | 32 | Total size in bytes |

## Verification
The bench builds the probe with CLK_MHZ=2 and SETTLE_US=3, so the settling wait is six cycles. This keeps a full probe near twenty cycles, which leaves room for dozens of random identifications. It still lets the exact gap between the last command write and the first read be counted. The default nine-entry device table is kept, so every table row, both vendor paths and the unmatched paths can all be reached. A manufacturer word with a non-zero upper byte shows that only the low byte is compared.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

  typedef enum logic [1:0] {
    VK_NONE   = 2'd0,
    VK_UNLOCK = 2'd1,
    VK_STATUS = 2'd2
  } vendor_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_CMD2, S_CMD3, S_SETTLE,
    S_RD_MFR, S_CAP_MFR, S_RD_DEV, S_CAP_DEV, S_RDMODE, S_DONE
  } probe_state_e;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_IDENT   = 8'h90;

  // Settling length in cycles, never below one.
  function automatic int settle_cycles(input int mhz, input int us);
    int n;
    n = mhz * us;
    return (n < 1) ? 1 : n;
  endfunction

  // Map the low byte of the manufacturer word onto a command family.
  function automatic vendor_kind_e vendor_of(input logic [7:0] code,
                                             input logic [7:0] a,
                                             input logic [7:0] b);
    if (code == a)      return VK_UNLOCK;
    else if (code == b) return VK_STATUS;
    else                return VK_NONE;
  endfunction

  // Command byte that returns a part of the given family to read mode.
  function automatic logic [7:0] readmode_cmd(input vendor_kind_e k);
    return (k == VK_STATUS) ? 8'hFF : 8'hF0;
  endfunction

endpackage

// File: rtl/probe_settle.sv
module probe_settle #(
  parameter int CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CW-1:0] START = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= START;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  // R3
  settle_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (CYC == 1) || !expired);
endmodule

// File: rtl/probe_classify.sv
module probe_classify #(
  parameter int DATA_W  = 16,
  parameter int NUM_DEV = 9,
  parameter int TYPE_W  = 4,
  parameter logic [NUM_DEV*DATA_W-1:0] DEV_CODES = '0,
  parameter logic [NUM_DEV*16-1:0]     DEV_SECTS = '0,
  parameter logic [NUM_DEV*32-1:0]     DEV_BYTES = '0
) (
  input  logic [DATA_W-1:0] dev_word,
  output logic              hit,
  output logic [TYPE_W-1:0] type_idx,
  output logic [15:0]       sects,
  output logic [31:0]       bytes
);
  logic [NUM_DEV-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_DEV; g++) begin : g_cmp
      assign match[g] = (dev_word == DEV_CODES[g*DATA_W +: DATA_W]);
    end
  endgenerate

  // Lowest matching entry wins.
  always_comb begin
    hit      = 1'b0;
    type_idx = '0;
    sects    = '0;
    bytes    = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        type_idx = TYPE_W'(i + 1);
        sects    = DEV_SECTS[i*16 +: 16];
        bytes    = DEV_BYTES[i*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nor_probe_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_US = 100,
  parameter logic [7:0] VEND_UNLOCK = 8'h01,
  parameter logic [7:0] VEND_STATUS = 8'h89,
  parameter int NUM_DEV   = 9,
  parameter int TYPE_W    = $clog2(NUM_DEV + 1),
  parameter logic [NUM_DEV*DATA_W-1:0] DEV_CODES = {
    16'h8899, 16'h88CD, 16'h8897, 16'h88C5, 16'h8891,
    16'h88C3, 16'h8893, 16'h88C1, 16'h22D7},
  parameter logic [NUM_DEV*16-1:0] DEV_SECTS = {
    16'd135, 16'd135, 16'd71, 16'd71, 16'd39,
    16'd39, 16'd23, 16'd23, 16'd128},
  parameter logic [NUM_DEV*32-1:0] DEV_BYTES = {
    32'h0080_0000, 32'h0080_0000, 32'h0040_0000, 32'h0040_0000, 32'h0020_0000,
    32'h0020_0000, 32'h0010_0000, 32'h0010_0000, 32'h0080_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        id_vendor,
  output logic [TYPE_W-1:0] id_type,
  output logic [15:0]       id_sectors,
  output logic [31:0]       id_bytes
);
  localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'('h2AA);
  localparam logic [ADDR_W-1:0] A_MFR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(1);

  function automatic logic [DATA_W-1:0] cmd_word(input logic [7:0] b);
    return {{(DATA_W-8){1'b0}}, b};
  endfunction

  probe_state_e state, nxt;
  vendor_kind_e kind_q, mfr_kind;

  // Named internal events
  logic ev_accept, ev_settle_load, ev_settle_run, ev_settle_end;
  logic ev_cap_mfr, ev_cap_dev, cls_hit;
  logic [TYPE_W-1:0] cls_type;
  logic [15:0] cls_sects;
  logic [31:0] cls_bytes;

  assign ev_accept      = (state == S_IDLE) && start;
  assign ev_settle_load = (state == S_CMD3);
  assign ev_settle_run  = (state == S_SETTLE);
  assign ev_cap_mfr     = (state == S_CAP_MFR);
  assign ev_cap_dev     = (state == S_CAP_DEV);
  assign mfr_kind       = vendor_of(bus_rdata[7:0], VEND_UNLOCK, VEND_STATUS);

  probe_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(ev_settle_load),
    .run(ev_settle_run), .expired(ev_settle_end));

  probe_classify #(
    .DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .TYPE_W(TYPE_W),
    .DEV_CODES(DEV_CODES), .DEV_SECTS(DEV_SECTS), .DEV_BYTES(DEV_BYTES)
  ) u_cls (
    .dev_word(bus_rdata), .hit(cls_hit), .type_idx(cls_type),
    .sects(cls_sects), .bytes(cls_bytes));

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (start) nxt = S_CMD1;
      S_CMD1:    nxt = S_CMD2;
      S_CMD2:    nxt = S_CMD3;
      S_CMD3:    nxt = S_SETTLE;
      S_SETTLE:  if (ev_settle_end) nxt = S_RD_MFR;
      S_RD_MFR:  nxt = S_CAP_MFR;
      S_CAP_MFR: nxt = (mfr_kind != VK_NONE) ? S_RD_DEV : S_DONE;
      S_RD_DEV:  nxt = S_CAP_DEV;
      S_CAP_DEV: nxt = cls_hit ? S_RDMODE : S_DONE;
      S_RDMODE:  nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind_q     <= VK_NONE;
      id_vendor  <= '0;
      id_type    <= '0;
      id_sectors <= '0;
      id_bytes   <= '0;
    end else begin
      state <= nxt;
      if (ev_accept) begin
        kind_q     <= VK_NONE;
        id_vendor  <= '0;
        id_type    <= '0;
        id_sectors <= '0;
        id_bytes   <= '0;
      end
      if (ev_cap_mfr) kind_q <= mfr_kind;
      if (ev_cap_dev && cls_hit) begin
        id_vendor  <= kind_q;
        id_type    <= cls_type;
        id_sectors <= cls_sects;
        id_bytes   <= cls_bytes;
      end
    end
  end

  always_comb begin
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state)
      S_CMD1:   begin bus_we = 1'b1; bus_addr = A_HI; bus_wdata = cmd_word(CMD_UNLOCK1); end
      S_CMD2:   begin bus_we = 1'b1; bus_addr = A_LO; bus_wdata = cmd_word(CMD_UNLOCK2); end
      S_CMD3:   begin bus_we = 1'b1; bus_addr = A_HI; bus_wdata = cmd_word(CMD_IDENT);   end
      S_RD_MFR: begin bus_re = 1'b1; bus_addr = A_MFR; end
      S_RD_DEV: begin bus_re = 1'b1; bus_addr = A_DEV; end
      S_RDMODE: begin bus_we = 1'b1; bus_addr = A_MFR; bus_wdata = cmd_word(readmode_cmd(kind_q)); end
      default:  ;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R10
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R2
  unlock_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HI && bus_wdata == cmd_word(8'hAA))
      |=> (bus_we && bus_addr == A_LO && bus_wdata == cmd_word(8'h55)));

  // R3
  quiet_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_settle_run |-> (!bus_we && !bus_re));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(id_sectors) && $stable(id_bytes) && $stable(id_vendor)));

  // R4
  unknown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && id_vendor == 2'd0) |-> (id_type == '0 && id_sectors == '0 && id_bytes == '0));

  // R7
  readmode_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MFR) |-> (bus_wdata == cmd_word(8'hF0) || bus_wdata == cmd_word(8'hFF)));
endmodule

// File: tb/nor_id_probe_test.sv
module nor_id_probe_test;
  localparam int AW = 12, DW = 16, TW = 4, ND = 9;
  localparam int MHZ = 2, SUS = 3;
  localparam int NSET = MHZ * SUS;
  localparam logic [7:0] VA = 8'h01, VB = 8'h89;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, bus_we, bus_re;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [1:0] id_vendor;
  logic [TW-1:0] id_type;
  logic [15:0] id_sectors;
  logic [31:0] id_bytes;

  always #2 clk = ~clk;

  nor_id_probe #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .SETTLE_US(SUS),
                 .VEND_UNLOCK(VA), .VEND_STATUS(VB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .id_vendor(id_vendor), .id_type(id_type),
    .id_sectors(id_sectors), .id_bytes(id_bytes));

  // Bench copy of the device table
  logic [15:0] t_code [ND] = '{16'h22D7, 16'h88C1, 16'h8893, 16'h88C3, 16'h8891,
                               16'h88C5, 16'h8897, 16'h88CD, 16'h8899};
  int          t_sect [ND] = '{128, 23, 23, 39, 39, 71, 71, 135, 135};
  int          t_mb   [ND] = '{8, 1, 1, 2, 2, 4, 4, 8, 8};

  int nvec = 0, nfail = 0, cyc = 0;
  logic [15:0] m_mfr, m_dev;
  int nw, nr;
  int w_cyc [8]; logic [AW-1:0] w_addr [8]; logic [DW-1:0] w_data [8];
  int r_cyc [8]; logic [AW-1:0] r_addr [8];

  always @(posedge clk) cyc <= cyc + 1;

  // Flash model: data only valid in the cycle after the read strobe (R9)
  always @(posedge clk) begin
    if (bus_re) bus_rdata <= (bus_addr == 0) ? m_mfr : (bus_addr == 1) ? m_dev : 16'hDEAD;
    else        bus_rdata <= 16'hBAD5;
  end

  always @(negedge clk) begin
    if (bus_we && nw < 8) begin w_cyc[nw] = cyc; w_addr[nw] = bus_addr; w_data[nw] = bus_wdata; nw = nw + 1; end
    if (bus_re && nr < 8) begin r_cyc[nr] = cyc; r_addr[nr] = bus_addr; nr = nr + 1; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_id(input logic [15:0] mfr, input logic [15:0] dev,
                           output int v, output int ty, output int s, output int b);
    v = 0; ty = 0; s = 0; b = 0;
    if (mfr[7:0] == VA) v = 1;
    else if (mfr[7:0] == VB) v = 2;
    if (v != 0) begin
      for (int i = ND - 1; i >= 0; i--)
        if (dev == t_code[i]) begin ty = i + 1; s = t_sect[i]; b = t_mb[i] << 20; end
      if (ty == 0) v = 0;
    end
  endtask

  task automatic run_probe(input logic [15:0] mfr, input logic [15:0] dev, input bit restart);
    int v, ty, s, b, ew, er, waited;
    logic [31:0] held;
    expect_id(mfr, dev, v, ty, s, b);
    m_mfr = mfr; m_dev = dev;
    @(negedge clk); nw = 0; nr = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    chk(done === 1'b1, "R8 done seen", done, 1);
    ew = (ty != 0) ? 4 : 3;
    er = (mfr[7:0] == VA || mfr[7:0] == VB) ? 2 : 1;
    chk(nw == ew, "R4/R5/R7/R8 write count", nw, ew);
    chk(nr == er, "R4/R5 read count", nr, er);
    chk(w_addr[0] == 12'h555 && w_data[0] == 16'h00AA, "R2 first write", {w_addr[0], w_data[0]}, 32'h555_00AA);
    chk(w_addr[1] == 12'h2AA && w_data[1] == 16'h0055 && w_cyc[1] == w_cyc[0] + 1, "R2 second write", {w_addr[1], w_data[1]}, 32'h2AA_0055);
    chk(w_addr[2] == 12'h555 && w_data[2] == 16'h0090 && w_cyc[2] == w_cyc[1] + 1, "R2 third write", {w_addr[2], w_data[2]}, 32'h555_0090);
    chk(r_cyc[0] - w_cyc[2] == NSET + 1, "R3 settle gap", r_cyc[0] - w_cyc[2], NSET + 1);
    chk(r_addr[0] == 0, "R4 mfr address", r_addr[0], 0);
    if (er == 2) chk(r_addr[1] == 1 && r_cyc[1] == r_cyc[0] + 2, "R5 dev address", r_addr[1], 1);
    if (ew == 4) chk(w_addr[3] == 0 && w_data[3] == ((v == 2) ? 16'h00FF : 16'h00F0),
                     "R7 read-mode command", w_data[3], (v == 2) ? 16'h00FF : 16'h00F0);
    chk(id_vendor == v[1:0], "R6 vendor", id_vendor, v);
    chk(id_type == ty[TW-1:0], "R6 type", id_type, ty);
    chk(id_sectors == s[15:0], "R6 sectors", id_sectors, s);
    chk(id_bytes == b, "R6 bytes", id_bytes, b);
    held = id_bytes;
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle", done, 0);
    @(negedge clk);
    chk(id_bytes == held && id_type == ty[TW-1:0], "R8 results held", id_bytes, held);
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_mfr = 0; m_dev = 0; nw = 0; nr = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !bus_we && !bus_re, "R1 idle after reset", {busy, done, bus_we, bus_re}, 0);
    chk(id_vendor == 0 && id_type == 0 && id_sectors == 0 && id_bytes == 0, "R1 results zero", id_bytes, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_probe(16'h0001, 16'h22D7, 1'b0);   // R6 unlock-style, first entry
    run_probe(16'h0089, 16'h8899, 1'b0);   // R6/R7 status-style, last entry
    run_probe(16'h0000, 16'h22D7, 1'b0);   // R4 unknown manufacturer
    run_probe(16'h0001, 16'h1234, 1'b0);   // R5 unknown device
    run_probe(16'hFF89, 16'h88C5, 1'b0);   // R4 upper byte ignored
    run_probe(16'h0089, 16'h00C5, 1'b0);   // R5 full-width compare
    run_probe(16'h0001, 16'h88CD, 1'b1);   // R8 start while busy ignored; R9 stray rdata ignored
    for (int k = 0; k < 40; k++) begin
      logic [15:0] mf, dv;
      int sel;
      sel = $urandom % 4;
      mf = {8'($urandom), (sel == 0) ? VA : (sel == 1) ? VB : (sel == 2) ? 8'h20 : 8'($urandom)};
      dv = ($urandom % 5 == 0) ? 16'($urandom) : t_code[$urandom % ND];
      run_probe(mf, dv, ($urandom % 6) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule